// File: doc/BRIEF.md
# Program Address Sequencer with Return Stack

This block produces the 13-bit instruction fetch address of a small Harvard-style controller core. On every instruction cycle it either moves to the next word, or it redirects. A redirect can be a direct jump, a subroutine call, a return, an accepted interrupt, or a computed jump. A computed jump happens when the core writes the counter's low byte as an ordinary data register.

An 8-entry hardware stack holds full return addresses. Calls and interrupts push onto it, and returns pop from it. The stack pointer wraps with no error indication.

A separate 5-bit page latch supplies the upper counter bits, but only when the low byte is written. Writing the latch alone never moves the counter. After every redirect the block raises a one-cycle discard signal so that the core can drop the word it has already prefetched. Devices with a smaller program store can set a parameter that clears the unused upper fetch-address bits.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rstN` is low, the counter, the page latch and the stack pointer are cleared and `flush` is 0, so the first fetch after reset is from address 0x0000.
- R2: When `stepEn` is the only action requested, the counter advances by one at the clock edge. It wraps from 0x1FFF to 0x0000.
- R3: `gotoEn` loads `jumpAddr` into all 13 counter bits. `callEn` does the same load and also pushes the address of the next word (counter + 1) onto the stack.
- R4: `pclWrEn` loads counter bits 7:0 from `wrData` and bits 12:8 from the page latch, in the same edge. `pclRdData` always shows counter bits 7:0.
- R5: `latchWrEn` stores `wrData[4:0]` in the page latch and leaves the counter unchanged. `latchRdData` shows the latch in bits 4:0, and bits 7:5 always read 0.
- R6: `irqTake` pushes the current counter value and loads the vector 0x0004.
- R7: `retEn` loads all 13 counter bits from the top stack entry and removes that entry.
- R8: The stack has 8 entries and a circular pointer. A ninth push overwrites the oldest entry. A pop from an empty stack returns whatever the slot below the pointer holds, and the pointer wraps.
- R9: `flush` is 1 for exactly the cycle that follows an edge at which a goto, call, return, interrupt or low-byte write was taken. After an edge with only a step, a latch write or no action, `flush` is 0.
- R10: `fetchAddr` equals the counter with the bits at and above log2(`PROG_WORDS`) forced to 0. With `PROG_WORDS`=2048, a counter of 0x1F34 fetches 0x0734.
- R11: When several counter actions are requested in one cycle, only one is taken. The order is: interrupt, then return, then call, then goto, then low-byte write, then step. A latch write is independent of the counter actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Advance to the next word |
| gotoEn | input | 1 | Jump to `jumpAddr` |
| callEn | input | 1 | Push the next address, then jump to `jumpAddr` |
| retEn | input | 1 | Pop the top stack entry into the counter |
| irqTake | input | 1 | Push the counter and jump to the interrupt vector |
| jumpAddr | input | 13 | Target address for goto and call |
| pclWrEn | input | 1 | Data write to the counter low byte |
| latchWrEn | input | 1 | Data write to the page latch |
| wrData | input | 8 | Write data for the low byte or the latch |
| fetchAddr | output | 13 | Fetch address, masked to the program size |
| pclRdData | output | 8 | Read value of the counter low byte |
| latchRdData | output | 8 | Read value of the page latch, upper 3 bits zero |
| flush | output | 1 | Discard the prefetched word |

## Verification
Stepping runs across the 0x1FFF boundary, which separates a true 13-bit wrap from a wider or narrower adder. Low-byte writes are made after latch writes with the upper bits set, so that a latch write that leaks into the counter, or a wrong latch bit slice, shows at once. Nine nested calls followed by nine returns separate circular overwrite from a saturating pointer. Combined requests (interrupt with call, return with goto, goto with low-byte write) expose any mistake in the priority order. A second instance with a 2K program size shows the fetch mask.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Strobes from the control decoder to the datapath; at most one of the
  // counter-load strobes is active in a cycle.
  typedef struct packed {
    logic incr;
    logic loadTarget;
    logic loadPcl;
    logic loadVector;
    logic pop;
    logic pushCur;
    logic pushNext;
    logic latchWr;
  } pcu_strobe_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepEn,
  input  logic        gotoEn,
  input  logic        callEn,
  input  logic        retEn,
  input  logic        irqTake,
  input  logic        pclWrEn,
  input  logic        latchWrEn,
  output pcu_strobe_t strobe,
  output logic        flush
);
  logic redirect;

  // Fixed priority: interrupt, return, call, goto, low-byte write, step.
  always_comb begin
    strobe = '0;
    strobe.latchWr = latchWrEn;
    if (irqTake) begin
      strobe.loadVector = 1'b1;
      strobe.pushCur    = 1'b1;
    end else if (retEn) begin
      strobe.pop = 1'b1;
    end else if (callEn) begin
      strobe.loadTarget = 1'b1;
      strobe.pushNext   = 1'b1;
    end else if (gotoEn) begin
      strobe.loadTarget = 1'b1;
    end else if (pclWrEn) begin
      strobe.loadPcl = 1'b1;
    end else if (stepEn) begin
      strobe.incr = 1'b1;
    end
  end

  assign redirect = strobe.loadVector | strobe.pop | strobe.loadTarget | strobe.loadPcl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flush <= 1'b0;
    else       flush <= redirect;
  end

  // R11: a single counter action per cycle
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.incr, strobe.loadTarget, strobe.loadPcl, strobe.loadVector, strobe.pop}));

  // R9: any flow change requested at the ports is followed by a discard cycle
  a_r9_flush_after_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (irqTake || retEn || callEn || gotoEn || pclWrEn) |=> flush);

  // R9: a cycle with no flow change is followed by no discard
  a_r9_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    !(irqTake || retEn || callEn || gotoEn || pclWrEn) |=> !flush);
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData
);
  localparam int SP_W = $clog2(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [SP_W-1:0]  sp;

  // The pointer names the next free slot; it wraps, so the ninth push lands
  // on the oldest entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[sp] <= pushData;
      sp        <= sp + SP_W'(1);
    end else if (pop) begin
      sp <= sp - SP_W'(1);
    end
  end

  assign topData = slots[sp - SP_W'(1)];

  // R8: the pointer moves up by one on a push, wrapping
  a_r8_push_moves: assert property (@(posedge clk) disable iff (!rstN)
    push |=> sp == $past(sp) + SP_W'(1));

  // R8: the pointer moves down by one on a pop, wrapping
  a_r8_pop_moves: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> sp == $past(sp) - SP_W'(1));

  // R7: the entry just pushed is the one a following pop returns
  a_r7_push_then_top: assert property (@(posedge clk) disable iff (!rstN)
    push |=> topData == $past(pushData));
endmodule

// File: rtl/pcu_dp.sv
module pcu_dp
  import pcu_pkg::*;
#(
  parameter int          PC_W        = 13,
  parameter int          DATA_W      = 8,
  parameter int          STACK_DEPTH = 8,
  parameter int          PROG_WORDS  = 8192,
  parameter logic [12:0] IRQ_VECTOR  = 13'h0004
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcu_strobe_t       strobe,
  input  logic [PC_W-1:0]   jumpAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [DATA_W-1:0] pclRdData,
  output logic [DATA_W-1:0] latchRdData
);
  localparam int PAGE_W = PC_W - DATA_W;
  localparam int USED_W = $clog2(PROG_WORDS);

  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pcNext;
  logic [PC_W-1:0]   pcPlusOne;
  logic [PAGE_W-1:0] pageLatch;
  logic [PC_W-1:0]   pushData;
  logic [PC_W-1:0]   topData;

  assign pcPlusOne = pc + PC_W'(1);
  assign pushData  = strobe.pushNext ? pcPlusOne : pc;

  pcu_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PC_W)) uStack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.pushCur | strobe.pushNext),
    .pop      (strobe.pop),
    .pushData (pushData),
    .topData  (topData)
  );

  always_comb begin
    pcNext = pc;
    if (strobe.loadVector)      pcNext = PC_W'(IRQ_VECTOR);
    else if (strobe.pop)        pcNext = topData;
    else if (strobe.loadTarget) pcNext = jumpAddr;
    else if (strobe.loadPcl)    pcNext = {pageLatch, wrData};
    else if (strobe.incr)       pcNext = pcPlusOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= '0;
      pageLatch <= '0;
    end else begin
      pc <= pcNext;
      if (strobe.latchWr) pageLatch <= wrData[PAGE_W-1:0];
    end
  end

  assign pclRdData   = pc[DATA_W-1:0];
  assign latchRdData = {{(DATA_W-PAGE_W){1'b0}}, pageLatch};

  generate
    if (USED_W < PC_W) begin : g_masked
      assign fetchAddr = {{(PC_W-USED_W){1'b0}}, pc[USED_W-1:0]};
    end else begin : g_full
      assign fetchAddr = pc;
    end
  endgenerate

  // R2: a lone step advances the counter by one
  a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incr |=> pc == $past(pc) + PC_W'(1));

  // R5: a latch write with no counter action leaves the counter alone
  a_r5_latch_keeps_pc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchWr && !(strobe.incr || strobe.loadTarget || strobe.loadPcl ||
      strobe.loadVector || strobe.pop)) |=> $stable(pc));

  // R6: an accepted interrupt lands on the vector
  a_r6_vector: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadVector |=> pc == PC_W'(IRQ_VECTOR));

  // R4: a low-byte write takes its upper bits from the page latch
  a_r4_pcl_page: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPcl |=> pc[PC_W-1:DATA_W] == $past(pageLatch));
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pcu_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 8,
  parameter int PROG_WORDS  = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              gotoEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              irqTake,
  input  logic [PC_W-1:0]   jumpAddr,
  input  logic              pclWrEn,
  input  logic              latchWrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [DATA_W-1:0] pclRdData,
  output logic [DATA_W-1:0] latchRdData,
  output logic              flush
);
  pcu_strobe_t strobe;

  pcu_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .gotoEn    (gotoEn),
    .callEn    (callEn),
    .retEn     (retEn),
    .irqTake   (irqTake),
    .pclWrEn   (pclWrEn),
    .latchWrEn (latchWrEn),
    .strobe    (strobe),
    .flush     (flush)
  );

  pcu_dp #(
    .PC_W        (PC_W),
    .DATA_W      (DATA_W),
    .STACK_DEPTH (STACK_DEPTH),
    .PROG_WORDS  (PROG_WORDS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .jumpAddr    (jumpAddr),
    .wrData      (wrData),
    .fetchAddr   (fetchAddr),
    .pclRdData   (pclRdData),
    .latchRdData (latchRdData)
  );
endmodule

// File: tb/pc_seq_unit_test.sv
`timescale 1ns/1ps
module pc_seq_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 0, gotoEn = 0, callEn = 0, retEn = 0, irqTake = 0;
  logic        pclWrEn = 0, latchWrEn = 0;
  logic [12:0] jumpAddr = '0;
  logic [7:0]  wrData = '0;
  logic [12:0] fetchAddr, smallFetch;
  logic [7:0]  pclRdData, latchRdData, smallPcl, smallLatch;
  logic        flush, smallFlush;

  always #2.5 clk = ~clk;

  pc_seq_unit uut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .gotoEn(gotoEn), .callEn(callEn),
    .retEn(retEn), .irqTake(irqTake), .jumpAddr(jumpAddr), .pclWrEn(pclWrEn),
    .latchWrEn(latchWrEn), .wrData(wrData), .fetchAddr(fetchAddr),
    .pclRdData(pclRdData), .latchRdData(latchRdData), .flush(flush));

  pc_seq_unit #(.PROG_WORDS(2048)) uutSmall (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .gotoEn(gotoEn), .callEn(callEn),
    .retEn(retEn), .irqTake(irqTake), .jumpAddr(jumpAddr), .pclWrEn(pclWrEn),
    .latchWrEn(latchWrEn), .wrData(wrData), .fetchAddr(smallFetch),
    .pclRdData(smallPcl), .latchRdData(smallLatch), .flush(smallFlush));

  typedef struct {
    string       req;
    int          due;
    logic [12:0] pc;
    logic        fl;
    logic [7:0]  latch;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0, failures = 0, cycleCnt = 0;
  bit   done = 0;

  // Reference state, kept from the requirements
  logic [12:0] mPc = '0;
  logic [4:0]  mLatch = '0;
  logic [12:0] mStack [8];
  logic [2:0]  mSp = '0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one request per cycle, expected result queued for the scoreboard
  task automatic drive(input string req, input bit st, input bit gt, input bit cl,
                       input bit rt, input bit ir, input bit pw, input bit lw,
                       input logic [12:0] tgt, input logic [7:0] wd);
    exp_t e;
    bit   redir;
    @(negedge clk);
    stepEn = st; gotoEn = gt; callEn = cl; retEn = rt; irqTake = ir;
    pclWrEn = pw; latchWrEn = lw; jumpAddr = tgt; wrData = wd;
    redir = ir | rt | cl | gt | pw;
    if (ir) begin
      mStack[mSp] = mPc; mSp = mSp + 3'd1; mPc = 13'h0004;
    end else if (rt) begin
      mSp = mSp - 3'd1; mPc = mStack[mSp];
    end else if (cl) begin
      mStack[mSp] = mPc + 13'd1; mSp = mSp + 3'd1; mPc = tgt;
    end else if (gt) begin
      mPc = tgt;
    end else if (pw) begin
      mPc = {mLatch, wd};
    end else if (st) begin
      mPc = mPc + 13'd1;
    end
    if (lw) mLatch = wd[4:0];
    e.req = req; e.due = cycleCnt + 1; e.pc = mPc; e.fl = redir; e.latch = {3'b000, mLatch};
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    drive(req, 0, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.req, "fetchAddr", int'(fetchAddr), int'(e.pc));
      check(e.req, "flush", int'(flush), int'(e.fl));
      check(e.req, "pclRdData", int'(pclRdData), int'(e.pc[7:0]));
      check(e.req, "latchRdData", int'(latchRdData), int'(e.latch));
      check("R10", "smallFetch", int'(smallFetch), int'(e.pc & 13'h07FF));
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mStack[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fetchAddr", int'(fetchAddr), 0);
    check("R1", "flush", int'(flush), 0);
    check("R1", "latchRdData", int'(latchRdData), 0);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) drive("R2", 1, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
    // R5: latch write, upper bits masked, counter held
    drive("R5", 0, 0, 0, 0, 0, 0, 1, 13'h0, 8'hFF);
    idle("R5");
    // R4 / R10: computed jump
    drive("R4", 0, 0, 0, 0, 0, 1, 0, 13'h0, 8'h34);
    idle("R9");
    // R2: wrap at the top of the address space
    drive("R4", 0, 0, 0, 0, 0, 1, 0, 13'h0, 8'hFE);
    drive("R2", 1, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
    drive("R2", 1, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
    // R5: latch write alongside a step, then a low-byte write with new page
    drive("R11", 1, 0, 0, 0, 0, 0, 1, 13'h0, 8'h0A);
    drive("R4", 0, 0, 0, 0, 0, 1, 0, 13'h0, 8'h55);
    // R3 / R7: goto, call and return
    drive("R3", 0, 1, 0, 0, 0, 0, 0, 13'h0123, 8'h0);
    drive("R3", 0, 0, 1, 0, 0, 0, 0, 13'h0456, 8'h0);
    drive("R2", 1, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
    drive("R7", 0, 0, 0, 1, 0, 0, 0, 13'h0, 8'h0);
    // R6: interrupt then return
    drive("R6", 0, 0, 0, 0, 1, 0, 0, 13'h0, 8'h0);
    drive("R2", 1, 0, 0, 0, 0, 0, 0, 13'h0, 8'h0);
    drive("R7", 0, 0, 0, 1, 0, 0, 0, 13'h0, 8'h0);
    // R11: combined requests
    drive("R11", 1, 0, 1, 0, 1, 0, 0, 13'h0777, 8'h0);
    drive("R11", 0, 1, 0, 1, 0, 0, 0, 13'h0999, 8'h0);
    drive("R11", 0, 1, 0, 0, 0, 1, 0, 13'h0ABC, 8'h11);
    idle("R9");
    // R8: nine nested calls, then nine returns
    for (int i = 0; i < 9; i++) drive("R8", 0, 0, 1, 0, 0, 0, 0, 13'h0100 + 13'(i * 16), 8'h0);
    for (int i = 0; i < 9; i++) drive("R8", 0, 0, 0, 1, 0, 0, 0, 13'h0, 8'h0);
    idle("R9");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule